// File: doc/BRIEF.md
# Asynchronous Static RAM Strobe Controller

This block sits between an internal valid/ready request bus and an external 128K x 8 asynchronous static RAM. It takes one read or write request at a time and plays it out on the RAM's pins as a fixed sequence of clocked phases. The RAM has an active-low select, an active-high select, an active-low output enable and an active-low write enable. The RAM is only reached when both selects are active. The controller leaves both selects inactive between transactions, which keeps the RAM in standby with its outputs floating.

Each phase length is a whole number of system clocks. The length is derived at elaboration from a nanosecond limit and the clock period, rounded up, with a minimum of one clock. A single parameter sets which strobe ends a write: write enable, or one of the two selects. The bidirectional data bus is split into drive value, sampled value and drive enable. The controller turns the bus around on its own. Its driver comes on only after output enable has been high for the output-disable time. The driver goes off again before output enable is next pulled low.

A read holds the access phase for the read cycle time. The controller samples the data on the last access clock and returns it with a one-clock valid pulse. A release phase then follows, in which output enable stays high while the RAM's outputs turn off.

Top module: `sramc_top`

## Requirements
- R1: While reset is high and on the first clock after it, the pins are idle. Idle means active-low select = 1, active-high select = 0, output enable = 1, write enable = 1 and data drive = 0. Ready is 1 and the response valid is 0.
- R2: A read asserts both selects, with write enable high and output enable low, for exactly RD consecutive clocks. RD is the read cycle time rounded up to whole clocks, at least 1. The address stays constant for the whole of that window.
- R3: Each read gives exactly one response-valid pulse, one clock long. The pulse comes in the clock after the last access clock. Its data is the value sampled on the data input during that last access clock.
- R4: In a write, the write condition (both selects active and write enable low) lasts exactly WP clocks, the write pulse time rounded up. Address and write data do not change during it.
- R5: The end-mode parameter picks which strobe ends a write. In mode 0 (end on write enable), write enable rises while both selects stay active. In mode 1 (end on low select), the active-low select rises while write enable stays low and the active-high select stays high. In mode 2 (end on high select), the active-high select falls while the other two stay active.
- R6: In the clock after the terminating edge, the address and the write data are still driven unchanged, with the data drive on.
- R7: The data drive turns on exactly SU clocks before the write condition begins. SU is the address setup time rounded up, at least 1.
- R8: The data drive is never on while output enable is low. The drive turns on only after output enable has been high for at least TA clocks, where TA is the output-disable time rounded up.
- R9: Output enable is high in every clock in which the write condition holds.
- R10: Ready drops on the clock after acceptance. It stays low for RD+TA clocks for a read and SU+WP+HD clocks for a write, where HD is the write recovery time rounded up and at least 1.
- R11: Whenever ready is high, both selects are inactive, output enable and write enable are high, and the data drive is off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request taken on this clock if valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | One-clock pulse with read data |
| rsp_rdata | output | DATA_W | Read data |
| mem_addr | output | ADDR_W | RAM address pins |
| mem_dq_out | output | DATA_W | Value driven onto the RAM data pins |
| mem_dq_in | input | DATA_W | Value sampled from the RAM data pins |
| mem_dq_oe | output | 1 | Enable of the data pin driver |
| mem_sel_n | output | 1 | Active-low chip select |
| mem_sel | output | 1 | Active-high chip select |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_we_n | output | 1 | Active-low write enable |

## Verification
The hardest case to reach is a write issued in the clock straight after a read, or the reverse. Only then does the margin between output enable and the data driver shrink to the release phase plus a single idle clock. Turnaround timing and the terminating edge of a write are otherwise hidden. The stimulus runs three controllers side by side, one per end mode, each fed the same back-to-back request stream. That stream includes a write immediately followed by a read of the same word, across many addresses. A pin-level RAM model beside each controller measures every strobe window and output-enable run, and stores data only on the falling edge of the write condition.

// File: rtl/sramc_pkg.sv
package sramc_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_RD_ACCESS,
        PH_RD_RELEASE,
        PH_WR_SETUP,
        PH_WR_STROBE,
        PH_WR_HOLD
    } phase_e;

    typedef enum logic [1:0] {
        END_ON_WE       = 2'd0,
        END_ON_SEL_LOW  = 2'd1,
        END_ON_SEL_HIGH = 2'd2
    } wr_end_e;

    typedef struct packed {
        logic sel_n;
        logic sel;
        logic oe_n;
        logic we_n;
        logic drive;
    } strobe_t;

    localparam strobe_t STROBE_IDLE = '{sel_n: 1'b1, sel: 1'b0, oe_n: 1'b1,
                                        we_n: 1'b1, drive: 1'b0};

    // Round a nanosecond limit up to whole clocks, never below one clock.
    function automatic int unsigned ns_to_clocks(input int unsigned ns,
                                                 input int unsigned period_ps);
        int unsigned c;
        c = (ns * 1000 + period_ps - 1) / period_ps;
        return (c == 0) ? 1 : c;
    endfunction

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    // Pin pattern for each phase. During the write phases, every strobe
    // except the terminating one is active from setup to hold; the
    // terminating strobe is active in the strobe phase only.
    function automatic strobe_t strobes_for(input phase_e ph, input wr_end_e mode);
        strobe_t s;
        s = STROBE_IDLE;
        case (ph)
            PH_RD_ACCESS: begin
                s.sel_n = 1'b0;
                s.sel   = 1'b1;
                s.oe_n  = 1'b0;
            end
            PH_WR_SETUP, PH_WR_STROBE, PH_WR_HOLD: begin
                s.drive = 1'b1;
                s.sel_n = 1'b0;
                s.sel   = 1'b1;
                s.we_n  = 1'b0;
                if (ph != PH_WR_STROBE) begin
                    case (mode)
                        END_ON_WE:      s.we_n  = 1'b1;
                        END_ON_SEL_LOW: s.sel_n = 1'b1;
                        default:        s.sel   = 1'b0;
                    endcase
                end
            end
            default: ;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/sramc_phase_timer.sv
module sramc_phase_timer #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             last
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign last = (cnt_q == '0);

endmodule

// File: rtl/sramc_sequencer.sv
module sramc_sequencer
    import sramc_pkg::*;
#(
    parameter int unsigned RD_LEN = 2,
    parameter int unsigned TA_LEN = 1,
    parameter int unsigned SU_LEN = 1,
    parameter int unsigned WP_LEN = 2,
    parameter int unsigned HD_LEN = 1,
    parameter int          CNT_W  = 2
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   req_valid,
    input  logic   req_write,
    output phase_e phase,
    output phase_e phase_nxt,
    output logic   accept,
    output logic   capture
);
    localparam logic [CNT_W-1:0] RD_M1 = CNT_W'(RD_LEN - 1);
    localparam logic [CNT_W-1:0] TA_M1 = CNT_W'(TA_LEN - 1);
    localparam logic [CNT_W-1:0] SU_M1 = CNT_W'(SU_LEN - 1);
    localparam logic [CNT_W-1:0] WP_M1 = CNT_W'(WP_LEN - 1);
    localparam logic [CNT_W-1:0] HD_M1 = CNT_W'(HD_LEN - 1);

    phase_e           phase_q;
    logic             last;
    logic [CNT_W-1:0] len_m1;

    assign phase   = phase_q;
    assign accept  = (phase_q == PH_IDLE) && req_valid;
    assign capture = (phase_q == PH_RD_ACCESS) && last;

    always_comb begin
        phase_nxt = phase_q;
        case (phase_q)
            PH_IDLE:       if (req_valid) phase_nxt = req_write ? PH_WR_SETUP : PH_RD_ACCESS;
            PH_RD_ACCESS:  if (last) phase_nxt = PH_RD_RELEASE;
            PH_RD_RELEASE: if (last) phase_nxt = PH_IDLE;
            PH_WR_SETUP:   if (last) phase_nxt = PH_WR_STROBE;
            PH_WR_STROBE:  if (last) phase_nxt = PH_WR_HOLD;
            PH_WR_HOLD:    if (last) phase_nxt = PH_IDLE;
            default:       phase_nxt = PH_IDLE;
        endcase
    end

    always_comb begin
        case (phase_nxt)
            PH_RD_ACCESS:  len_m1 = RD_M1;
            PH_RD_RELEASE: len_m1 = TA_M1;
            PH_WR_SETUP:   len_m1 = SU_M1;
            PH_WR_STROBE:  len_m1 = WP_M1;
            PH_WR_HOLD:    len_m1 = HD_M1;
            default:       len_m1 = '0;
        endcase
    end

    sramc_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .load    (phase_nxt != phase_q),
        .load_val(len_m1),
        .last    (last)
    );

    always_ff @(posedge clk) begin
        if (rst)
            phase_q <= PH_IDLE;
        else
            phase_q <= phase_nxt;
    end

    // R10: a write always returns to idle after its hold phase.
    assert_hold_to_idle_R10: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_WR_HOLD && phase_nxt != PH_WR_HOLD) |=> phase_q == PH_IDLE);

    // R3: read data is captured only at the end of an access phase.
    assert_capture_then_release_R3: assert property (@(posedge clk) disable iff (rst)
        capture |=> phase_q == PH_RD_RELEASE);

endmodule

// File: rtl/sramc_pin_driver.sv
module sramc_pin_driver
    import sramc_pkg::*;
#(
    parameter int      ADDR_W   = 17,
    parameter int      DATA_W   = 8,
    parameter wr_end_e END_MODE = END_ON_WE
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  logic              capture,
    input  phase_e            phase,
    input  phase_e            phase_nxt,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [DATA_W-1:0] mem_dq_in,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dq_out,
    output strobe_t           pins,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata
);
    strobe_t           pins_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] rdata_q;
    logic              rvalid_q;

    // Strobes are registered from the next phase so each pin is a flop.
    always_ff @(posedge clk) begin
        if (rst)
            pins_q <= STROBE_IDLE;
        else
            pins_q <= strobes_for(phase_nxt, END_MODE);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (accept) begin
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q  <= '0;
            rvalid_q <= 1'b0;
        end else begin
            rvalid_q <= capture;
            if (capture)
                rdata_q <= mem_dq_in;
        end
    end

    assign pins       = pins_q;
    assign mem_addr   = addr_q;
    assign mem_dq_out = wdata_q;
    assign rsp_valid  = rvalid_q;
    assign rsp_rdata  = rdata_q;

    assert_no_contention_R8: assert property (@(posedge clk) disable iff (rst)
        !(pins_q.drive && !pins_q.oe_n));

    assert_drive_after_disable_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(pins_q.drive) |-> $past(pins_q.oe_n));

    assert_oe_high_in_write_R9: assert property (@(posedge clk) disable iff (rst)
        (!pins_q.sel_n && pins_q.sel && !pins_q.we_n) |-> pins_q.oe_n);

    assert_addr_stable_R4: assert property (@(posedge clk) disable iff (rst)
        (phase != PH_IDLE && $past(phase) != PH_IDLE) |-> ($stable(addr_q) && $stable(wdata_q)));

    assert_single_pulse_R3: assert property (@(posedge clk) disable iff (rst)
        rvalid_q |=> !rvalid_q);

endmodule

// File: rtl/sramc_top.sv
module sramc_top
    import sramc_pkg::*;
#(
    parameter int          ADDR_W        = 17,
    parameter int          DATA_W        = 8,
    parameter int unsigned CLK_PERIOD_PS = 8000,
    parameter int unsigned T_CYCLE_NS    = 15,
    parameter int unsigned T_PULSE_NS    = 12,
    parameter int unsigned T_SETUP_NS    = 0,
    parameter int unsigned T_RECOVER_NS  = 0,
    parameter int unsigned T_DISABLE_NS  = 5,
    parameter wr_end_e     END_MODE      = END_ON_WE
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dq_out,
    input  logic [DATA_W-1:0] mem_dq_in,
    output logic              mem_dq_oe,
    output logic              mem_sel_n,
    output logic              mem_sel,
    output logic              mem_oe_n,
    output logic              mem_we_n
);
    localparam int unsigned RD_LEN  = ns_to_clocks(T_CYCLE_NS, CLK_PERIOD_PS);
    localparam int unsigned WP_LEN  = ns_to_clocks(T_PULSE_NS, CLK_PERIOD_PS);
    localparam int unsigned SU_LEN  = ns_to_clocks(T_SETUP_NS, CLK_PERIOD_PS);
    localparam int unsigned HD_LEN  = ns_to_clocks(T_RECOVER_NS, CLK_PERIOD_PS);
    localparam int unsigned TA_LEN  = ns_to_clocks(T_DISABLE_NS, CLK_PERIOD_PS);
    localparam int unsigned MAX_LEN = max2(max2(RD_LEN, WP_LEN),
                                           max2(max2(SU_LEN, HD_LEN), TA_LEN));
    localparam int          CNT_W   = $clog2(MAX_LEN + 1);

    phase_e  phase;
    phase_e  phase_nxt;
    logic    accept;
    logic    capture;
    strobe_t pins;

    sramc_sequencer #(
        .RD_LEN(RD_LEN), .TA_LEN(TA_LEN), .SU_LEN(SU_LEN),
        .WP_LEN(WP_LEN), .HD_LEN(HD_LEN), .CNT_W(CNT_W)
    ) u_seq (
        .clk      (clk),
        .rst      (rst),
        .req_valid(req_valid),
        .req_write(req_write),
        .phase    (phase),
        .phase_nxt(phase_nxt),
        .accept   (accept),
        .capture  (capture)
    );

    sramc_pin_driver #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .END_MODE(END_MODE)
    ) u_pins (
        .clk       (clk),
        .rst       (rst),
        .accept    (accept),
        .capture   (capture),
        .phase     (phase),
        .phase_nxt (phase_nxt),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .mem_dq_in (mem_dq_in),
        .mem_addr  (mem_addr),
        .mem_dq_out(mem_dq_out),
        .pins      (pins),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata)
    );

    assign req_ready = (phase == PH_IDLE);
    assign mem_sel_n = pins.sel_n;
    assign mem_sel   = pins.sel;
    assign mem_oe_n  = pins.oe_n;
    assign mem_we_n  = pins.we_n;
    assign mem_dq_oe = pins.drive;

    // R11: while idle and ready, the RAM sits in standby.
    assert_standby_when_ready_R11: assert property (@(posedge clk) disable iff (rst)
        (req_ready && $past(req_ready)) |-> (mem_sel_n && !mem_sel && !mem_dq_oe));

endmodule

// File: tb/tb_sramc_top.sv
module tb_sram_model #(
    parameter int MODE = 0,
    parameter int SU   = 1,
    parameter int WP   = 2,
    parameter int RD   = 3,
    parameter int TA   = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [16:0] addr,
    input  logic [7:0]  dq_out,
    output logic [7:0]  dq_in,
    input  logic        dq_oe,
    input  logic        sel_n,
    input  logic        sel,
    input  logic        oe_n,
    input  logic        we_n,
    input  logic        ready,
    output int          n_chk,
    output int          n_err
);
    logic [7:0] mem [256];
    logic wa, ra;
    logic p_wa, p_ra, p_oe;
    logic [16:0] p_addr;
    logic [7:0] p_dq;
    int wa_run, ra_run, drv_run, oeh_run;

    assign wa = !sel_n && sel && !we_n;
    assign ra = !sel_n && sel && we_n && !oe_n;
    assign dq_in = ra ? mem[addr[7:0]] : 8'hEE;

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'(i) ^ 8'h5A;
        n_chk = 0; n_err = 0;
        p_wa = 0; p_ra = 0; p_oe = 0; p_addr = '0; p_dq = '0;
        wa_run = 0; ra_run = 0; drv_run = 0; oeh_run = 100;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s (end mode %0d): actual %0d expected %0d", req, MODE, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            chk(!(dq_oe && !oe_n), "R8 driver on while output enable low", int'(dq_oe), 0);
            if (ready)
                chk(sel_n && !sel && we_n && oe_n && !dq_oe, "R11 standby while ready",
                    int'({sel_n, sel, oe_n, we_n, dq_oe}), 5'b10110);
            if (wa && !p_wa) chk(drv_run == SU, "R7 drive-on to write start", drv_run, SU);
            if (wa) chk(dq_oe && oe_n, "R9 output enable high in write", int'({dq_oe, oe_n}), 3);
            if (wa && p_wa)
                chk(addr == p_addr && dq_out == p_dq, "R4 address/data stable in write",
                    int'(dq_out), int'(p_dq));
            if (!wa && p_wa) begin
                chk(wa_run == WP, "R4 write condition width", wa_run, WP);
                case (MODE)
                    0: chk({sel_n, sel, we_n} == 3'b011, "R5 end on write enable",
                           int'({sel_n, sel, we_n}), 3'b011);
                    1: chk({sel_n, sel, we_n} == 3'b110, "R5 end on low select",
                           int'({sel_n, sel, we_n}), 3'b110);
                    default: chk({sel_n, sel, we_n} == 3'b000, "R5 end on high select",
                           int'({sel_n, sel, we_n}), 3'b000);
                endcase
                chk(addr == p_addr && dq_out == p_dq && dq_oe, "R6 hold after end of write",
                    int'(dq_out), int'(p_dq));
                mem[p_addr[7:0]] = p_dq;
            end
            if (dq_oe && !p_oe) chk(oeh_run >= TA, "R8 turnaround before drive", oeh_run, TA);
            if (ra && p_ra) chk(addr == p_addr, "R2 address stable in read", int'(addr), int'(p_addr));
            if (!ra && p_ra) chk(ra_run == RD, "R2 read window width", ra_run, RD);
        end
        wa_run  = wa ? wa_run + 1 : 0;
        ra_run  = ra ? ra_run + 1 : 0;
        drv_run = dq_oe ? drv_run + 1 : 0;
        oeh_run = oe_n ? oeh_run + 1 : 0;
        p_wa = wa; p_ra = ra; p_oe = dq_oe; p_addr = addr; p_dq = dq_out;
    end
endmodule

module tb_sramc_top;
    import sramc_pkg::*;

    localparam int PER_PS = 8000;
    localparam int C_NS = 20, P_NS = 15, S_NS = 0, H_NS = 0, D_NS = 12;

    function automatic int cyc(input int ns);
        int c;
        c = (ns * 1000 + PER_PS - 1) / PER_PS;
        return (c < 1) ? 1 : c;
    endfunction

    localparam int RD = (C_NS * 1000 + PER_PS - 1) / PER_PS;
    localparam int WP = (P_NS * 1000 + PER_PS - 1) / PER_PS;
    localparam int SU = 1;
    localparam int HD = 1;
    localparam int TA = (D_NS * 1000 + PER_PS - 1) / PER_PS;

    logic clk = 0;
    logic rst = 1;
    always #4 clk = ~clk;

    logic        req_valid = 0, req_write = 0;
    logic [16:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;

    logic        rdy [3];
    logic        rv [3];
    logic [7:0]  rd [3];
    logic [16:0] ma [3];
    logic [7:0]  mo [3], mi [3];
    logic        moe [3], msn [3], ms [3], mon [3], mwn [3];
    int          mchk [3], merr [3];

    sramc_top #(.CLK_PERIOD_PS(PER_PS), .T_CYCLE_NS(C_NS), .T_PULSE_NS(P_NS),
        .T_SETUP_NS(S_NS), .T_RECOVER_NS(H_NS), .T_DISABLE_NS(D_NS), .END_MODE(END_ON_WE)) dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(rdy[0]), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rv[0]), .rsp_rdata(rd[0]),
        .mem_addr(ma[0]), .mem_dq_out(mo[0]), .mem_dq_in(mi[0]), .mem_dq_oe(moe[0]),
        .mem_sel_n(msn[0]), .mem_sel(ms[0]), .mem_oe_n(mon[0]), .mem_we_n(mwn[0]));
    sramc_top #(.CLK_PERIOD_PS(PER_PS), .T_CYCLE_NS(C_NS), .T_PULSE_NS(P_NS),
        .T_SETUP_NS(S_NS), .T_RECOVER_NS(H_NS), .T_DISABLE_NS(D_NS), .END_MODE(END_ON_SEL_LOW)) dut_lo (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(rdy[1]), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rv[1]), .rsp_rdata(rd[1]),
        .mem_addr(ma[1]), .mem_dq_out(mo[1]), .mem_dq_in(mi[1]), .mem_dq_oe(moe[1]),
        .mem_sel_n(msn[1]), .mem_sel(ms[1]), .mem_oe_n(mon[1]), .mem_we_n(mwn[1]));
    sramc_top #(.CLK_PERIOD_PS(PER_PS), .T_CYCLE_NS(C_NS), .T_PULSE_NS(P_NS),
        .T_SETUP_NS(S_NS), .T_RECOVER_NS(H_NS), .T_DISABLE_NS(D_NS), .END_MODE(END_ON_SEL_HIGH)) dut_hi (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(rdy[2]), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rv[2]), .rsp_rdata(rd[2]),
        .mem_addr(ma[2]), .mem_dq_out(mo[2]), .mem_dq_in(mi[2]), .mem_dq_oe(moe[2]),
        .mem_sel_n(msn[2]), .mem_sel(ms[2]), .mem_oe_n(mon[2]), .mem_we_n(mwn[2]));

    tb_sram_model #(.MODE(0), .SU(SU), .WP(WP), .RD(RD), .TA(TA)) m0 (
        .clk(clk), .rst(rst), .addr(ma[0]), .dq_out(mo[0]), .dq_in(mi[0]), .dq_oe(moe[0]),
        .sel_n(msn[0]), .sel(ms[0]), .oe_n(mon[0]), .we_n(mwn[0]), .ready(rdy[0]),
        .n_chk(mchk[0]), .n_err(merr[0]));
    tb_sram_model #(.MODE(1), .SU(SU), .WP(WP), .RD(RD), .TA(TA)) m1 (
        .clk(clk), .rst(rst), .addr(ma[1]), .dq_out(mo[1]), .dq_in(mi[1]), .dq_oe(moe[1]),
        .sel_n(msn[1]), .sel(ms[1]), .oe_n(mon[1]), .we_n(mwn[1]), .ready(rdy[1]),
        .n_chk(mchk[1]), .n_err(merr[1]));
    tb_sram_model #(.MODE(2), .SU(SU), .WP(WP), .RD(RD), .TA(TA)) m2 (
        .clk(clk), .rst(rst), .addr(ma[2]), .dq_out(mo[2]), .dq_in(mi[2]), .dq_oe(moe[2]),
        .sel_n(msn[2]), .sel(ms[2]), .oe_n(mon[2]), .we_n(mwn[2]), .ready(rdy[2]),
        .n_chk(mchk[2]), .n_err(merr[2]));

    int   n_chk = 0, n_err = 0;
    bit   done = 0;
    logic [7:0] exp_mem [256];

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic summary();
        int tc, te;
        tc = n_chk; te = n_err;
        for (int k = 0; k < 3; k++) begin tc += mchk[k]; te += merr[k]; end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", tc, te);
    endtask

    task automatic check_idle_R1();
        for (int k = 0; k < 3; k++) begin
            chk({msn[k], ms[k], mon[k], mwn[k], moe[k]} == 5'b10110, "R1 idle pins",
                int'({msn[k], ms[k], mon[k], mwn[k], moe[k]}), 5'b10110);
            chk(rdy[k] && !rv[k], "R1 ready/valid", int'({rdy[k], rv[k]}), 2'b10);
        end
    endtask

    task automatic txn(input bit wr, input logic [16:0] a, input logic [7:0] d);
        int n, busy, seen, exp_busy;
        req_valid = 1; req_write = wr; req_addr = a; req_wdata = d;
        while (!rdy[0]) @(negedge clk);
        @(negedge clk);
        req_valid = 0;
        busy = 0; seen = 0; n = 1;
        while (!rdy[0] && n < 100) begin
            busy++;
            if (rv[0] || rv[1] || rv[2]) begin
                seen++;
                chk(n == RD + 1 && rv[0] && rv[1] && rv[2], "R3 response timing", n, RD + 1);
                for (int k = 0; k < 3; k++)
                    chk(rd[k] == exp_mem[a[7:0]], "R3 read data", int'(rd[k]), int'(exp_mem[a[7:0]]));
            end
            @(negedge clk);
            n++;
        end
        if (rv[0] || rv[1] || rv[2]) seen++;
        exp_busy = wr ? (SU + WP + HD) : (RD + TA);
        chk(busy == exp_busy, "R10 busy length", busy, exp_busy);
        chk(rdy[1] == rdy[0] && rdy[2] == rdy[0], "R10 ready agreement", int'({rdy[1], rdy[2]}), 3);
        chk(seen == (wr ? 0 : 1), "R3 pulse count", seen, wr ? 0 : 1);
        if (wr) exp_mem[a[7:0]] = d;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_err++;
            n_chk++;
            $display("FAIL R10 watchdog: actual 1 expected 0");
            summary();
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 256; i++) exp_mem[i] = 8'(i) ^ 8'h5A;
        chk(cyc(C_NS) == RD && cyc(P_NS) == WP && cyc(S_NS) == SU && cyc(D_NS) == TA,
            "R2 derived clock counts", RD, cyc(C_NS));
        repeat (3) @(negedge clk);
        check_idle_R1();
        rst = 0;
        @(negedge clk);
        check_idle_R1();
        // R2 R3: read the initial pattern at every low address
        for (int a = 0; a < 256; a++)
            txn(1'b0, {9'((a * 113) & 511), 8'(a)}, 8'h00);
        // R4 R5 R6 R7: write every low address
        for (int a = 0; a < 256; a++)
            txn(1'b1, {9'(a ^ 9'h1A5), 8'(a)}, 8'((a * 37 + 11) & 255));
        // R3: read back what was written
        for (int a = 0; a < 256; a++)
            txn(1'b0, {9'(a), 8'(a)}, 8'h00);
        // R8: write immediately followed by read of the same word, both turnarounds
        for (int a = 0; a < 64; a++) begin
            txn(1'b1, {9'(a * 5), 8'(a * 3)}, 8'((a * 91 + 7) & 255));
            txn(1'b0, {9'(a * 5), 8'(a * 3)}, 8'h00);
        end
        @(negedge clk);
        check_idle_R1();
        done = 1;
        summary();
        $finish;
    end
endmodule